// File: doc/BRIEF.md
# Serial Audio Receive Word Packer

This block turns a serial audio data line into 32-bit words for a receive FIFO. A single-cycle bit strobe `bclk_tick` marks each sampling point. On each strobe the block takes one data bit, most significant bit first. A frame starts on a frame sync pulse, and the source of that pulse depends on the mode. In slave mode the pulse arrives on `fs_in`. In master mode the block makes the pulse itself and drives it on `fs_out`.

A frame holds one or two sub-frames. Each sub-frame has `CH_PER_SUB` channels, and each channel lasts `CH_BITS` strobes. Reception always begins with the first channel of sub-frame 0. In each channel the first L bits form a word, and any bits after them are thrown away. The word is then extended with zeros or with its sign bit. The target width is 32 bits in normal mode and 16 bits in halfword mode. In halfword mode two consecutive words are joined into one FIFO entry, with the first word in the low half.

The control path is a three-state receive machine: `ST_IDLE` waits for a frame start, `ST_SHIFT` takes word bits, and `ST_PAD` skips the rest of a channel. Its transitions are:
- IDLE→SHIFT on a frame start.
- SHIFT→PAD when the word is complete before the channel ends.
- SHIFT→SHIFT or PAD→SHIFT at a channel boundary.
- Any state→IDLE after the last bit of the frame, or when `rx_en` is low.
- SHIFT or PAD→SHIFT (restart) when a slave sync arrives in the middle of a frame.

A second two-state machine handles pairing: `PK_EMPTY` goes to `PK_LOW` when a low half is stored, and `PK_LOW` returns to `PK_EMPTY` when the pair is written or `rx_en` falls.

Top module: `srx_word_packer`

## Requirements
- R1: Word bits are sampled MSB first on `bclk_tick` cycles. The word length L is `cfg_wlen`+1 (1 to 32 bits). The received word is right-aligned, so the first sampled bit ends up at bit L-1.
- R2: With `cfg_sign`=0, every bit at position L or above in the written value is 0.
- R3: With `cfg_sign`=1, every bit at position L or above, up to the extension width, is a copy of word bit L-1.
- R4: Each channel is `CH_BITS` strobes long and gives exactly one word. Bits after the first L in a channel do not affect any written value.
- R5: In slave mode a frame starts on a strobe where `fs_in`=1 and `rx_en`=1. That strobe's bit is the MSB of channel 0. A sync during a frame restarts the frame there and drops the partial word.
- R6: In master mode `fs_out` is high only on the strobe that starts a frame. Frames follow each other with no gap, each lasting `CH_BITS`·`CH_PER_SUB`·(1+`cfg_two_sub`) strobes. `fs_in` has no effect in this mode.
- R7: A frame gives `CH_PER_SUB` words when `cfg_two_sub`=0 and 2·`CH_PER_SUB` words when it is 1. After a slave frame ends, bits are ignored until the next sync.
- R8: With `cfg_half`=1:
  - L is capped at 16.
  - Words are extended to 16 bits.
  - Each pair of consecutive words is written as one entry: {second[15:0], first[15:0]}.
- R9: In halfword mode, a stored low half is dropped when `rx_en` goes low. The next word received becomes a new low half.
- R10: When a write is due while `fifo_full`=1:
  - `fifo_wr` stays low and the word is lost.
  - `ovf` goes to 1 and stays at 1 until reset.
- R11: While reset is held, `fifo_wr`, `ovf` and `fs_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_tick | input | 1 | Single-cycle bit sampling strobe |
| sd_in | input | 1 | Serial data line |
| fs_in | input | 1 | Incoming frame sync (slave mode) |
| fs_out | output | 1 | Generated frame sync (master mode) |
| cfg_master | input | 1 | 1 = master mode, 0 = slave mode |
| cfg_two_sub | input | 1 | 1 = two sub-frames per frame |
| cfg_half | input | 1 | 1 = halfword packing mode |
| cfg_sign | input | 1 | 1 = sign extension, 0 = zero extension |
| cfg_wlen | input | 5 | Word length minus one |
| rx_en | input | 1 | Reception enable |
| fifo_full | input | 1 | Receive FIFO full |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | FIFO write data |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench targets several corner cases, and each one exposes a specific kind of fault:
- **Very short words (1 and 5 bits) with random padding bits.** A design that let padding bits leak into the word would write values with stray upper bits.
- **Halfword mode with a pending low half when `rx_en` is toggled.** A design that kept the stale half would write an entry built from words of two different bursts.
- **A slave sync in the middle of a channel, and data after a slave frame ends with no new sync.** Failing to restart, or continuing to run freely, would give extra or misaligned entries.
- **Master framing.** A stray `fs_out` pulse, or a sync arriving on `fs_in` that disturbs the frame, is caught on every strobe.
- **Writes while the FIFO is full.** A design that did not hold `ovf` or did not drop the word would fail here.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int FIFO_W = 32;
    localparam int HALF_W = 16;
    localparam int LEN_W  = 6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_PAD   = 2'd2
    } rx_state_e;

    typedef enum logic {
        PK_EMPTY = 1'b0,
        PK_LOW   = 1'b1
    } pk_state_e;

endpackage

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int CH_BITS    = 32,
    parameter int CH_PER_SUB = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                sd,
    input  logic                fs_in,
    input  logic                master,
    input  logic                two_sub,
    input  logic                rx_en,
    input  logic [LEN_W-1:0]    len,
    output logic                fs_out,
    output logic                done,
    output logic [FIFO_W-1:0]   raw
);

    localparam int BW = $clog2(CH_BITS);
    localparam int CW = (CH_PER_SUB > 1) ? $clog2(2 * CH_PER_SUB) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(CH_BITS - 1);
    localparam logic [CW-1:0] LAST_CH1 = CW'(CH_PER_SUB - 1);
    localparam logic [CW-1:0] LAST_CH2 = CW'(2 * CH_PER_SUB - 1);

    rx_state_e          state, state_d, nxt;
    logic [BW-1:0]      bitc, b;
    logic [CW-1:0]      chan, ch;
    logic [FIFO_W-2:0]  sh;
    logic               start, in_frame, sampling, end_bit, end_ch, word_end;
    logic [31:0]        b_next, len32;

    // Position decode for the current strobe
    always_comb begin
        start    = tick && rx_en && (master ? (state == ST_IDLE) : fs_in);
        in_frame = tick && rx_en && (start || (state != ST_IDLE));
        b        = start ? '0 : bitc;
        ch       = start ? '0 : chan;
        sampling = start || (state == ST_SHIFT);
        end_bit  = (b == LAST_BIT);
        end_ch   = (ch == (two_sub ? LAST_CH2 : LAST_CH1));
        b_next   = 32'(b) + 32'd1;
        len32    = 32'(len);
        word_end = in_frame && sampling && (b_next == len32);
        if (end_bit && end_ch)  nxt = ST_IDLE;
        else if (end_bit)       nxt = ST_SHIFT;
        else if (b_next < len32) nxt = ST_SHIFT;
        else                    nxt = ST_PAD;
    end

    // Next-state logic
    always_comb begin
        state_d = state;
        if (!rx_en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (start) state_d = nxt;
                ST_SHIFT: if (tick)  state_d = nxt;
                ST_PAD:   if (tick)  state_d = nxt;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Outputs
    always_comb begin
        fs_out = master && start;
    end

    // Counters, shifter and word hand-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitc <= '0;
            chan <= '0;
            sh   <= '0;
            done <= 1'b0;
            raw  <= '0;
        end else begin
            done <= word_end;
            if (!rx_en) begin
                bitc <= '0;
                chan <= '0;
            end else if (in_frame) begin
                if (end_bit) begin
                    bitc <= '0;
                    chan <= end_ch ? '0 : ch + 1'b1;
                end else begin
                    bitc <= b + 1'b1;
                    chan <= ch;
                end
                if (sampling) sh <= {sh[FIFO_W-3:0], sd};
                if (word_end) raw <= {sh, sd};
            end
        end
    end

endmodule

// File: rtl/srx_extend.sv
module srx_extend
    import srx_pkg::*;
(
    input  logic [FIFO_W-1:0] raw,
    input  logic [LEN_W-1:0]  len,
    input  logic              sign,
    input  logic              half,
    output logic [FIFO_W-1:0] ext
);

    logic [FIFO_W-1:0] mask, full;
    logic [LEN_W-1:0]  top;
    logic              msb;

    always_comb begin
        mask = (FIFO_W'(1) << len) - FIFO_W'(1);
        top  = len - 1'b1;
        msb  = raw[top[4:0]];
        full = (sign && msb) ? (raw | ~mask) : (raw & mask);
        ext  = half ? {{(FIFO_W-HALF_W){1'b0}}, full[HALF_W-1:0]} : full;
    end

endmodule

// File: rtl/srx_packer.sv
module srx_packer
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              half,
    input  logic              done,
    input  logic [FIFO_W-1:0] word,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [FIFO_W-1:0] fifo_wdata,
    output logic              ovf
);

    pk_state_e          pk, pk_d;
    logic [HALF_W-1:0]  low;
    logic               wr_req;

    // Next-state logic for the pairing machine
    always_comb begin
        pk_d = pk;
        if (!rx_en) begin
            pk_d = PK_EMPTY;
        end else if (done && half) begin
            unique case (pk)
                PK_EMPTY: pk_d = PK_LOW;
                PK_LOW:   pk_d = PK_EMPTY;
                default:  pk_d = PK_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pk <= PK_EMPTY;
        else        pk <= pk_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low        <= '0;
            wr_req     <= 1'b0;
            fifo_wdata <= '0;
            ovf        <= 1'b0;
        end else begin
            wr_req <= 1'b0;
            if (rx_en && done) begin
                if (!half) begin
                    wr_req     <= 1'b1;
                    fifo_wdata <= word;
                end else if (pk == PK_EMPTY) begin
                    low <= word[HALF_W-1:0];
                end else begin
                    wr_req     <= 1'b1;
                    fifo_wdata <= {word[HALF_W-1:0], low};
                end
            end
            if (wr_req && fifo_full) ovf <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        fifo_wr = wr_req && !fifo_full;
    end

endmodule

// File: rtl/srx_word_packer.sv
module srx_word_packer
    import srx_pkg::*;
#(
    parameter int CH_BITS    = 32,
    parameter int CH_PER_SUB = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bclk_tick,
    input  logic        sd_in,
    input  logic        fs_in,
    output logic        fs_out,
    input  logic        cfg_master,
    input  logic        cfg_two_sub,
    input  logic        cfg_half,
    input  logic        cfg_sign,
    input  logic [4:0]  cfg_wlen,
    input  logic        rx_en,
    input  logic        fifo_full,
    output logic        fifo_wr,
    output logic [31:0] fifo_wdata,
    output logic        ovf
);

    localparam int CAP_FULL = (CH_BITS < FIFO_W) ? CH_BITS : FIFO_W;
    localparam int CAP_HALF = (CH_BITS < HALF_W) ? CH_BITS : HALF_W;

    logic [LEN_W-1:0]  len_cfg, len_lim, len;
    logic              done;
    logic [FIFO_W-1:0] raw, ext;

    always_comb begin
        len_cfg = {1'b0, cfg_wlen} + 1'b1;
        len_lim = cfg_half ? LEN_W'(CAP_HALF) : LEN_W'(CAP_FULL);
        len     = (len_cfg > len_lim) ? len_lim : len_cfg;
    end

    srx_framer #(.CH_BITS(CH_BITS), .CH_PER_SUB(CH_PER_SUB)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (bclk_tick),
        .sd      (sd_in),
        .fs_in   (fs_in),
        .master  (cfg_master),
        .two_sub (cfg_two_sub),
        .rx_en   (rx_en),
        .len     (len),
        .fs_out  (fs_out),
        .done    (done),
        .raw     (raw)
    );

    srx_extend u_extend (
        .raw  (raw),
        .len  (len),
        .sign (cfg_sign),
        .half (cfg_half),
        .ext  (ext)
    );

    srx_packer u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .half       (cfg_half),
        .done       (done),
        .word       (ext),
        .fifo_full  (fifo_full),
        .fifo_wr    (fifo_wr),
        .fifo_wdata (fifo_wdata),
        .ovf        (ovf)
    );

endmodule

// File: rtl/srx_checker.sv
module srx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bclk_tick,
    input logic        fs_out,
    input logic        cfg_master,
    input logic        cfg_half,
    input logic        cfg_sign,
    input logic [4:0]  cfg_wlen,
    input logic        rx_en,
    input logic        fifo_full,
    input logic        fifo_wr,
    input logic [31:0] fifo_wdata,
    input logic        ovf
);

    logic [5:0] wl;
    assign wl = {1'b0, cfg_wlen} + 6'd1;

    assert_no_write_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> !fifo_full);

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    assert_sync_only_master_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fs_out |-> (cfg_master && bclk_tick && rx_en));

    assert_write_after_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> $past(rx_en));

    assert_zero_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && !cfg_half && !cfg_sign) |-> ((fifo_wdata >> wl) == 32'd0));

    assert_sync_not_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fs_out |=> !fs_out);

endmodule

bind srx_word_packer srx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_tick  (bclk_tick),
    .fs_out     (fs_out),
    .cfg_master (cfg_master),
    .cfg_half   (cfg_half),
    .cfg_sign   (cfg_sign),
    .cfg_wlen   (cfg_wlen),
    .rx_en      (rx_en),
    .fifo_full  (fifo_full),
    .fifo_wr    (fifo_wr),
    .fifo_wdata (fifo_wdata),
    .ovf        (ovf)
);

// File: tb/tb_srx_word_packer.sv
module tb_srx_word_packer;

    localparam int CH = 32;
    localparam int CPS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk_tick = 1'b0, sd_in = 1'b0, fs_in = 1'b0;
    logic fs_out;
    logic cfg_master = 1'b0, cfg_two_sub = 1'b0, cfg_half = 1'b0, cfg_sign = 1'b0;
    logic [4:0] cfg_wlen = 5'd23;
    logic rx_en = 1'b0, fifo_full = 1'b0;
    logic fifo_wr;
    logic [31:0] fifo_wdata;
    logic ovf;

    always #4 clk = ~clk;

    srx_word_packer #(.CH_BITS(CH), .CH_PER_SUB(CPS)) dut (
        .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick), .sd_in(sd_in),
        .fs_in(fs_in), .fs_out(fs_out), .cfg_master(cfg_master),
        .cfg_two_sub(cfg_two_sub), .cfg_half(cfg_half), .cfg_sign(cfg_sign),
        .cfg_wlen(cfg_wlen), .rx_en(rx_en), .fifo_full(fifo_full),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .ovf(ovf)
    );

    logic [31:0] exp_q[$];
    string       tag_q[$];
    int          n_cmp = 0, n_bad = 0;
    bit          pend_e = 0;
    logic [15:0] low_e;
    bit          sink_full = 0;
    bit          finished = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_ext(input logic [31:0] w, input int L, input int W, input bit s);
        logic [31:0] r = '0;
        for (int i = 0; i < W; i++) r[i] = (i < L) ? w[i] : (s ? w[L-1] : 1'b0);
        return r;
    endfunction

    function automatic void expect_word(input logic [31:0] w, input int L, input string tag);
        logic [31:0] e;
        if (cfg_half) begin
            e = model_ext(w, L, 16, cfg_sign);
            if (pend_e) begin
                pend_e = 0;
                if (!sink_full) begin exp_q.push_back({e[15:0], low_e}); tag_q.push_back(tag); end
            end else begin
                low_e = e[15:0];
                pend_e = 1;
            end
        end else begin
            e = model_ext(w, L, 32, cfg_sign);
            if (!sink_full) begin exp_q.push_back(e); tag_q.push_back(tag); end
        end
    endfunction

    // Monitor: compares each FIFO write with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && fifo_wr) begin
            if (exp_q.size() == 0) begin
                chk(0, "unexpected write R4/R7", fifo_wdata, 0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(fifo_wdata === e, t, fifo_wdata, e);
            end
        end
    end

    task automatic tick(input logic sd, input logic fs, output logic fso);
        @(negedge clk);
        sd_in = sd; fs_in = fs; bclk_tick = 1'b1;
        #1 fso = fs_out;
        @(negedge clk);
        bclk_tick = 1'b0; fs_in = 1'b0;
    endtask

    task automatic send_chan(input logic [31:0] w, input int L, input bit first, input string tag);
        logic fso;
        for (int b = 0; b < CH; b++) begin
            logic bitv, fsv;
            bitv = (b < L) ? w[L-1-b] : 1'($urandom);
            fsv  = cfg_master ? 1'($urandom) : (first && b == 0);
            tick(bitv, fsv, fso);
            chk(fso === (cfg_master && first && b == 0), "R6 fs_out", fso, cfg_master && first && b == 0);
        end
    endtask

    task automatic send_frame(input int nch, input string tag);
        int L, effL;
        L = int'(cfg_wlen) + 1;
        effL = (cfg_half && L > 16) ? 16 : L;
        for (int c = 0; c < nch; c++) begin
            logic [31:0] w;
            w = $urandom;
            w[L-1] = (c % 2 == 0);
            expect_word(w >> (L - effL), effL, tag);
            send_chan(w, L, c == 0, tag);
        end
    endtask

    function automatic int frame_ch();
        return cfg_two_sub ? 2 * CPS : CPS;
    endfunction

    task automatic drain(input string tag);
        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    task automatic restart();
        logic fso;
        rx_en = 1'b0;
        tick(1'b0, 1'b0, fso);
        pend_e = 0;
        rx_en = 1'b1;
    endtask

    initial begin
        logic fso;
        repeat (3) @(negedge clk);
        chk(fifo_wr === 1'b0, "R11 fifo_wr", fifo_wr, 0);
        chk(ovf === 1'b0, "R11 ovf", ovf, 0);
        chk(fs_out === 1'b0, "R11 fs_out", fs_out, 0);
        rst_n = 1'b1;

        // Slave, 24-bit words, zero fill
        cfg_wlen = 5'd23; cfg_sign = 0; restart();
        repeat (2) send_frame(frame_ch(), "R1/R2 slave zero fill");
        drain("R1 drain");

        // Sign fill, 20-bit words
        cfg_wlen = 5'd19; cfg_sign = 1; restart();
        repeat (2) send_frame(frame_ch(), "R3 sign fill");
        drain("R3 drain");

        // Two sub-frames, full 32-bit words, then stray bits with no sync
        cfg_wlen = 5'd31; cfg_sign = 0; cfg_two_sub = 1; restart();
        repeat (2) send_frame(frame_ch(), "R7 two sub-frames");
        for (int i = 0; i < 40; i++) tick(1'($urandom), 1'b0, fso);
        drain("R7 no sync no words");
        cfg_two_sub = 0;

        // Very short words with random padding
        cfg_wlen = 5'd0; cfg_sign = 1; restart();
        send_frame(frame_ch(), "R4 one-bit words");
        cfg_wlen = 5'd4; cfg_sign = 0; restart();
        send_frame(frame_ch(), "R4 five-bit words");
        drain("R4 drain");

        // Mid-channel resync in slave mode
        cfg_wlen = 5'd23; cfg_sign = 0; restart();
        for (int i = 0; i < 10; i++) tick(1'($urandom), i == 0, fso);
        send_frame(frame_ch(), "R5 resync");
        drain("R5 drain");

        // Halfword packing, zero and sign, and length capping
        cfg_half = 1; cfg_wlen = 5'd15; cfg_sign = 0; restart();
        repeat (2) send_frame(frame_ch(), "R8 half zero");
        cfg_wlen = 5'd11; cfg_sign = 1; restart();
        repeat (2) send_frame(frame_ch(), "R8 half sign");
        cfg_wlen = 5'd23; cfg_sign = 0; restart();
        repeat (2) send_frame(frame_ch(), "R8 half capped");
        drain("R8 drain");

        // Pending low half dropped when reception is disabled
        cfg_wlen = 5'd15; restart();
        begin
            logic [31:0] w;
            w = $urandom;
            expect_word(w & 32'hFFFF, 16, "R9 stale half");
            send_chan(w, 16, 1'b1, "R9 stale half");
        end
        restart();
        send_frame(frame_ch(), "R9 fresh pair");
        drain("R9 drain");
        cfg_half = 0;

        // Overflow
        cfg_wlen = 5'd23; restart();
        chk(ovf === 1'b0, "R10 ovf before", ovf, 0);
        fifo_full = 1; sink_full = 1;
        send_frame(frame_ch(), "R10 full");
        drain("R10 dropped");
        chk(ovf === 1'b1, "R10 ovf set", ovf, 1);
        fifo_full = 0; sink_full = 0;
        send_frame(frame_ch(), "R10 after full");
        drain("R10 drain");
        chk(ovf === 1'b1, "R10 ovf sticky", ovf, 1);

        // Master mode, back-to-back frames, fs_in noise
        cfg_master = 1; cfg_two_sub = 1; rx_en = 1'b0; restart();
        repeat (2) send_frame(frame_ch(), "R6 master");
        drain("R6 drain");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R11 watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule